// File: doc/BRIEF.md
# Trace Message Packetizer

This block turns one debug trace message into a stream of 12-bit output beats, one beat per clock, with a 2-bit sideband code on every beat. It handles two message kinds. A write message carries a type code, a source ID, a data-size code, the significant bits of an address and the write data. A branch message carries a type code, a source ID and an instruction count.

The header fields have fixed widths and are packed first, lowest bit first. The variable fields follow. The address, or the instruction count in a branch message, continues right after the header bits. The write data always starts on a fresh beat. Each variable packet is padded with zeros up to the end of its last beat.

The sideband code tells the receiver where packets and messages end. A message is handed over with a valid/ready handshake and is held inside the block while it streams out. A new message is taken only after the end-of-message beat of the current one has been driven.

Top module: `trc_packetizer`

## Requirements
- R1: Out of reset, and whenever no message is streaming, `sb_o` is 2'b11, `beat_o` is zero and `ready_o` is high.
- R2: A message is accepted on a clock edge where `valid_i` and `ready_o` are both high. Its first beat appears in the cycle after that edge. Its beats follow one per clock with no gaps, and `ready_o` stays low until the last beat has been driven.
- R3: The first beat of a write message (`is_branch_i`=0) carries the type code in bits 5:0, the source ID in bits 9:6 and size code bits 1:0 in bits 11:10. Its sideband code is 2'b00.
- R4: In a write message, bit 0 of the second beat is size code bit 2. The low `var_len_i` address bits follow from bit 1 upward, lowest bit first, running on into later beats as needed. The unused bits of the last address beat are zero, and that beat carries sideband code 2'b01.
- R5: `var_len_i` gives the number of significant address or count bits, 1 to 32. Bits of `var_i` at or above that length do not reach the output.
- R6: Write data starts on a new beat, lowest bit first. Its width is 8 bits for size code 3'b000, 16 bits for 3'b001, and 32 bits for any other code. Data bits above that width are not sent, and padding is zero. The last data beat carries 2'b11.
- R7: A branch message (`is_branch_i`=1) carries the type code in bits 5:0 and the source ID in bits 9:6 of the first beat. The low `var_len_i` count bits follow from bit 10 on, zero padded, and the message ends with 2'b11. A branch message has no size field.
- R8: Every beat that ends neither a packet nor the message carries 2'b00. When one beat is both the first and the last beat of a message, it carries 2'b11.
- R9: Changes on the message inputs while a message is streaming do not alter that message's beats. A request held valid during streaming is accepted only once `ready_o` returns high.
- R10: After each end-of-message beat, the next cycle is an idle cycle with `ready_o` high, before any beat of a later message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Message request |
| ready_o | output | 1 | Block can take a message |
| is_branch_i | input | 1 | 1: branch message, 0: write message |
| tcode_i | input | 6 | Message type code |
| src_i | input | 4 | Source ID |
| size_i | input | 3 | Write data size code |
| var_i | input | 32 | Address (write) or instruction count (branch) |
| var_len_i | input | 6 | Significant bits of `var_i`, 1 to 32 |
| data_i | input | 32 | Write data |
| beat_o | output | 12 | Output data beat |
| sb_o | output | 2 | Sideband code for the beat |

## Verification
The assertions assume that `var_len_i` lies between 1 and 32 whenever `valid_i` is high; one of them checks this input rule directly. The header checks on the first beat assume the default 12-bit beat with 6-, 4- and 3-bit header fields. With those widths, a write message always needs at least two beats, so its first beat is never an end beat. The stimulus draws every length from the legal range and uses all eight size codes. It also sets address and data bits above the selected width, so that the masking can be observed at the outputs.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    SB_BEAT    = 2'b00,
    SB_PKT_END = 2'b01,
    SB_MSG_END = 2'b11
  } sb_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PKT0 = 2'd1,
    ST_PKT1 = 2'd2
  } st_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/trc_field_pack.sv
module trc_field_pack
  import trc_pkg::*;
#(
  parameter int BEAT_W  = 12,
  parameter int TCODE_W = 6,
  parameter int SRC_W   = 4,
  parameter int SIZE_W  = 3,
  parameter int VAR_W   = 32,
  parameter int DATA_W  = 32,
  localparam int LEN_W  = $clog2(VAR_W + 1),
  localparam int HDR_W  = TCODE_W + SRC_W + SIZE_W,
  localparam int P0_BT  = ceil_div(HDR_W + VAR_W, BEAT_W),
  localparam int P1_BT  = ceil_div(DATA_W, BEAT_W),
  localparam int P0_W   = P0_BT * BEAT_W,
  localparam int P1_W   = P1_BT * BEAT_W,
  localparam int N0_W   = $clog2(P0_BT + 1),
  localparam int N1_W   = $clog2(P1_BT + 1)
) (
  input  logic               is_branch_i,
  input  logic [TCODE_W-1:0] tcode_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [VAR_W-1:0]   var_i,
  input  logic [LEN_W-1:0]   var_len_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [P0_W-1:0]    p0_o,
  output logic [N0_W-1:0]    n0_o,
  output logic [P1_W-1:0]    p1_o,
  output logic [N1_W-1:0]    n1_o,
  output logic               has_p1_o
);
  localparam int DB_W  = $clog2(DATA_W + 1);
  localparam int SUM_W = $clog2(P0_W + P1_W + BEAT_W + 1);

  logic [VAR_W-1:0]  var_m;
  logic [DATA_W-1:0] data_m;
  logic [DB_W-1:0]   dbits;
  logic [SUM_W-1:0]  p0_bits;
  logic [SUM_W-1:0]  p1_bits;

  // keep only the significant low bits of the variable field
  for (genvar i = 0; i < VAR_W; i++) begin : g_var_mask
    assign var_m[i] = var_i[i] & (LEN_W'(i) < var_len_i);
  end

  always_comb begin
    unique case (size_i)
      SIZE_W'(0): dbits = DB_W'(8);
      SIZE_W'(1): dbits = DB_W'(16);
      default:    dbits = DB_W'(DATA_W);
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_data_mask
    assign data_m[i] = data_i[i] & (DB_W'(i) < dbits);
  end

  always_comb begin
    p0_o = '0;
    p0_o[TCODE_W-1:0]       = tcode_i;
    p0_o[TCODE_W +: SRC_W]  = src_i;
    if (is_branch_i) begin
      p0_o[TCODE_W+SRC_W +: VAR_W] = var_m;
    end else begin
      p0_o[TCODE_W+SRC_W +: SIZE_W] = size_i;
      p0_o[HDR_W +: VAR_W]          = var_m;
    end
  end

  assign p0_bits  = SUM_W'(is_branch_i ? (TCODE_W + SRC_W) : HDR_W) + SUM_W'(var_len_i);
  assign p1_bits  = SUM_W'(dbits);
  assign n0_o     = N0_W'((p0_bits + SUM_W'(BEAT_W - 1)) / SUM_W'(BEAT_W));
  assign n1_o     = N1_W'((p1_bits + SUM_W'(BEAT_W - 1)) / SUM_W'(BEAT_W));
  assign p1_o     = P1_W'(data_m);
  assign has_p1_o = ~is_branch_i;
endmodule

// File: rtl/trc_beat_seq.sv
module trc_beat_seq
  import trc_pkg::*;
#(
  parameter int BEAT_W = 12,
  parameter int P0_W   = 48,
  parameter int P1_W   = 36,
  parameter int N0_W   = 3,
  parameter int N1_W   = 2,
  localparam int CNT_W = max_int(N0_W, N1_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [P0_W-1:0]   p0_i,
  input  logic [N0_W-1:0]   n0_i,
  input  logic [P1_W-1:0]   p1_i,
  input  logic [N1_W-1:0]   n1_i,
  input  logic              has_p1_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic [1:0]        sb_o,
  output logic              busy_o
);
  st_e              st_q;
  logic [P0_W-1:0]  sh0_q;
  logic [P1_W-1:0]  sh1_q;
  logic [N1_W-1:0]  n1_q;
  logic             has1_q;
  logic [CNT_W-1:0] left_q;
  logic             last;

  assign last = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh0_q  <= '0;
      sh1_q  <= '0;
      n1_q   <= '0;
      has1_q <= 1'b0;
      left_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_PKT0;
            sh0_q  <= p0_i;
            sh1_q  <= p1_i;
            n1_q   <= n1_i;
            has1_q <= has_p1_i;
            left_q <= CNT_W'(n0_i - N0_W'(1));
          end
        end
        ST_PKT0: begin
          if (last) begin
            if (has1_q) begin
              st_q   <= ST_PKT1;
              left_q <= CNT_W'(n1_q - N1_W'(1));
            end else begin
              st_q <= ST_IDLE;
            end
          end else begin
            sh0_q  <= sh0_q >> BEAT_W;
            left_q <= left_q - CNT_W'(1);
          end
        end
        ST_PKT1: begin
          if (last) begin
            st_q <= ST_IDLE;
          end else begin
            sh1_q  <= sh1_q >> BEAT_W;
            left_q <= left_q - CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    beat_o = '0;
    sb_o   = SB_MSG_END;
    unique case (st_q)
      ST_PKT0: begin
        beat_o = sh0_q[BEAT_W-1:0];
        sb_o   = !last ? SB_BEAT : (has1_q ? SB_PKT_END : SB_MSG_END);
      end
      ST_PKT1: begin
        beat_o = sh1_q[BEAT_W-1:0];
        sb_o   = last ? SB_MSG_END : SB_BEAT;
      end
      default: ;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/trc_packetizer.sv
module trc_packetizer
  import trc_pkg::*;
#(
  parameter int BEAT_W  = 12,
  parameter int TCODE_W = 6,
  parameter int SRC_W   = 4,
  parameter int SIZE_W  = 3,
  parameter int VAR_W   = 32,
  parameter int DATA_W  = 32,
  localparam int LEN_W  = $clog2(VAR_W + 1),
  localparam int HDR_W  = TCODE_W + SRC_W + SIZE_W,
  localparam int P0_BT  = ceil_div(HDR_W + VAR_W, BEAT_W),
  localparam int P1_BT  = ceil_div(DATA_W, BEAT_W),
  localparam int P0_W   = P0_BT * BEAT_W,
  localparam int P1_W   = P1_BT * BEAT_W,
  localparam int N0_W   = $clog2(P0_BT + 1),
  localparam int N1_W   = $clog2(P1_BT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic               is_branch_i,
  input  logic [TCODE_W-1:0] tcode_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [VAR_W-1:0]   var_i,
  input  logic [LEN_W-1:0]   var_len_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [BEAT_W-1:0]  beat_o,
  output logic [1:0]         sb_o
);
  logic            busy;
  logic            accept;
  logic [P0_W-1:0] p0;
  logic [P1_W-1:0] p1;
  logic [N0_W-1:0] n0;
  logic [N1_W-1:0] n1;
  logic            has_p1;

  assign ready_o = ~busy;
  assign accept  = valid_i & ready_o;

  trc_field_pack #(
    .BEAT_W (BEAT_W),
    .TCODE_W(TCODE_W),
    .SRC_W  (SRC_W),
    .SIZE_W (SIZE_W),
    .VAR_W  (VAR_W),
    .DATA_W (DATA_W)
  ) u_pack (
    .is_branch_i(is_branch_i),
    .tcode_i    (tcode_i),
    .src_i      (src_i),
    .size_i     (size_i),
    .var_i      (var_i),
    .var_len_i  (var_len_i),
    .data_i     (data_i),
    .p0_o       (p0),
    .n0_o       (n0),
    .p1_o       (p1),
    .n1_o       (n1),
    .has_p1_o   (has_p1)
  );

  trc_beat_seq #(
    .BEAT_W(BEAT_W),
    .P0_W  (P0_W),
    .P1_W  (P1_W),
    .N0_W  (N0_W),
    .N1_W  (N1_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .p0_i    (p0),
    .n0_i    (n0),
    .p1_i    (p1),
    .n1_i    (n1),
    .has_p1_i(has_p1),
    .beat_o  (beat_o),
    .sb_o    (sb_o),
    .busy_o  (busy)
  );
endmodule

// File: rtl/trc_packetizer_chk.sv
module trc_packetizer_chk #(
  parameter int BEAT_W  = 12,
  parameter int TCODE_W = 6,
  parameter int SRC_W   = 4,
  parameter int VAR_W   = 32,
  localparam int LEN_W  = $clog2(VAR_W + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               ready_o,
  input logic               is_branch_i,
  input logic [TCODE_W-1:0] tcode_i,
  input logic [SRC_W-1:0]   src_i,
  input logic [1:0]         size_lo_i,
  input logic [LEN_W-1:0]   var_len_i,
  input logic [BEAT_W-1:0]  beat_o,
  input logic [1:0]         sb_o
);
  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sb_o == 2'b11 && beat_o == '0)); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o); // R2

  AST_WRITE_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !is_branch_i) |=>
      (sb_o == 2'b00 && beat_o[TCODE_W-1:0] == $past(tcode_i) &&
       beat_o[TCODE_W +: SRC_W] == $past(src_i) &&
       beat_o[BEAT_W-1 -: 2] == $past(size_lo_i))); // R3

  AST_BRANCH_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && is_branch_i) |=>
      (beat_o[TCODE_W-1:0] == $past(tcode_i) &&
       beat_o[TCODE_W +: SRC_W] == $past(src_i))); // R7

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (var_len_i >= LEN_W'(1) && var_len_i <= LEN_W'(VAR_W))); // R5

  AST_DATA_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb_o == 2'b01) |=> (!ready_o && sb_o != 2'b01)); // R6

  AST_END_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb_o == 2'b11 && !ready_o) |=> ready_o); // R10

  AST_READY_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(sb_o) == 2'b11)); // R2
endmodule

bind trc_packetizer trc_packetizer_chk #(
  .BEAT_W (BEAT_W),
  .TCODE_W(TCODE_W),
  .SRC_W  (SRC_W),
  .VAR_W  (VAR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .is_branch_i(is_branch_i),
  .tcode_i    (tcode_i),
  .src_i      (src_i),
  .size_lo_i  (size_i[1:0]),
  .var_len_i  (var_len_i),
  .beat_o     (beat_o),
  .sb_o       (sb_o)
);

// File: tb/tb_trc_packetizer.sv
module tb_trc_packetizer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic        is_branch_i = 1'b0;
  logic [5:0]  tcode_i = '0;
  logic [3:0]  src_i = '0;
  logic [2:0]  size_i = '0;
  logic [31:0] var_i = '0;
  logic [5:0]  var_len_i = 6'd1;
  logic [31:0] data_i = '0;
  logic [11:0] beat_o;
  logic [1:0]  sb_o;

  always #5 clk_i = ~clk_i;

  trc_packetizer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .is_branch_i(is_branch_i), .tcode_i(tcode_i), .src_i(src_i), .size_i(size_i),
    .var_i(var_i), .var_len_i(var_len_i), .data_i(data_i),
    .beat_o(beat_o), .sb_o(sb_o)
  );

  logic [13:0] exp_q[$];
  string       tag_q[$];
  string       force_tag = "";
  int          total = 0;
  int          bad = 0;
  bit          busy_m = 0;
  bit          just_ended = 0;
  bit          run = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // expected beats from the requirements
  task automatic push_msg(input bit br, input logic [5:0] tc, input logic [3:0] sr,
                          input logic [2:0] sz, input logic [31:0] v,
                          input logic [5:0] len, input logic [31:0] d);
    logic [63:0] p0, vm, pd;
    int bits0, n0, dw, n1;
    string t;
    vm = {32'd0, v} & ((64'd1 << len) - 64'd1);
    if (br) begin
      p0 = 64'(tc) | (64'(sr) << 6) | (vm << 10);
      bits0 = 10 + int'(len);
    end else begin
      p0 = 64'(tc) | (64'(sr) << 6) | (64'(sz) << 10) | (vm << 13);
      bits0 = 13 + int'(len);
    end
    n0 = (bits0 + 11) / 12;
    for (int i = 0; i < n0; i++) begin
      logic [1:0] sb;
      sb = (i == n0 - 1) ? (br ? 2'b11 : 2'b01) : 2'b00;
      if (br) t = "R7";
      else if (i == 0) t = "R3";
      else if (({32'd0, v} >> len) != 0) t = "R5";
      else t = "R4";
      if (force_tag != "") t = force_tag;
      exp_q.push_back({sb, p0[i*12 +: 12]});
      tag_q.push_back(t);
    end
    if (!br) begin
      dw = (sz == 3'd0) ? 8 : (sz == 3'd1) ? 16 : 32;
      pd = {32'd0, d} & ((64'd1 << dw) - 64'd1);
      n1 = (dw + 11) / 12;
      for (int i = 0; i < n1; i++) begin
        exp_q.push_back({(i == n1 - 1) ? 2'b11 : 2'b00, pd[i*12 +: 12]});
        tag_q.push_back(force_tag != "" ? force_tag : "R6");
      end
    end
  endtask

  task automatic drive(input bit br, input logic [5:0] tc, input logic [3:0] sr,
                       input logic [2:0] sz, input logic [31:0] v,
                       input logic [5:0] len, input logic [31:0] d);
    is_branch_i = br; tcode_i = tc; src_i = sr; size_i = sz;
    var_i = v; var_len_i = len; data_i = d;
  endtask

  task automatic send(input bit br, input logic [5:0] tc, input logic [3:0] sr,
                      input logic [2:0] sz, input logic [31:0] v,
                      input logic [5:0] len, input logic [31:0] d);
    @(posedge clk_i); #1;
    while (!ready_o) begin @(posedge clk_i); #1; end
    drive(br, tc, sr, sz, v, len, d);
    push_msg(br, tc, sr, sz, v, len, d);
    valid_i = 1'b1;
    @(posedge clk_i); #1;
    valid_i = 1'b0;
  endtask

  // monitor: pops expected beats, checks idle cycles between messages
  always @(negedge clk_i) begin
    if (rst_ni && run) begin
      if (busy_m) begin
        chk(!ready_o, "R2", "ready during message", 32'(ready_o), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected beat", 32'(beat_o), 32'd0);
          busy_m = 0;
        end else begin
          logic [13:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(beat_o == e[11:0], t, "beat data", 32'(beat_o), 32'(e[11:0]));
          chk(sb_o == e[13:12], (t == "R9") ? t : "R8", "sideband",
              32'(sb_o), 32'(e[13:12]));
          if (e[13:12] == 2'b11) begin
            busy_m = 0;
            just_ended = 1;
          end
        end
      end else begin
        chk(sb_o == 2'b11 && beat_o == '0, just_ended ? "R10" : "R1", "idle beat",
            {18'd0, sb_o, beat_o}, {18'd0, 2'b11, 12'd0});
        chk(ready_o, just_ended ? "R10" : "R1", "ready idle", 32'(ready_o), 32'd1);
        just_ended = 0;
        if (valid_i && ready_o) busy_m = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", exp_q.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(sb_o == 2'b11 && beat_o == '0 && ready_o, "R1", "reset state",
        {17'd0, ready_o, sb_o, beat_o}, {17'd0, 1'b1, 2'b11, 12'd0});
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    run = 1;

    // R3 R4 R6: short address, byte data
    send(0, 6'h06, 4'h3, 3'd0, 32'h0000_000A, 6'd4, 32'h0000_00C5);
    // R4 R6: full address, word data
    send(0, 6'h2B, 4'hF, 3'd2, 32'hDEAD_BEEF, 6'd32, 32'hCAFE_F00D);
    // R5 R6: address and data bits above width must vanish
    send(0, 6'h11, 4'h5, 3'd1, 32'hFFFF_FFFF, 6'd1, 32'hFFFF_1234);
    // R6: size code outside 0/1 selects 32 bits
    send(0, 6'h3F, 4'h0, 3'd7, 32'h0000_0155, 6'd9, 32'h8000_0001);
    // R7: branch messages
    send(1, 6'h04, 4'hA, 3'd0, 32'h0000_00A5, 6'd8, 32'h0);
    send(1, 6'h04, 4'h1, 3'd5, 32'hFFFF_FFFF, 6'd2, 32'h0); // R8 single beat
    send(1, 6'h1C, 4'h7, 3'd0, 32'h8765_4321, 6'd32, 32'h0);

    // R9: inputs change and valid stays high while a message streams
    force_tag = "R9";
    send(0, 6'h2A, 4'h9, 3'd1, 32'h0000_0ABC, 6'd12, 32'h0000_5A5A);
    force_tag = "";
    drive(1, 6'h15, 4'h2, 3'd3, 32'h0000_0033, 6'd6, 32'h1111_1111);
    push_msg(1, 6'h15, 4'h2, 3'd3, 32'h0000_0033, 6'd6, 32'h1111_1111);
    valid_i = 1'b1;
    while (!ready_o) begin @(posedge clk_i); #1; end
    @(posedge clk_i); #1;
    valid_i = 1'b0;

    for (int k = 0; k < 40; k++) begin
      send(1'($urandom_range(0, 1)), 6'($urandom), 4'($urandom), 3'($urandom),
           $urandom, 6'($urandom_range(1, 32)), $urandom);
    end

    while (exp_q.size() != 0 || busy_m) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule